// File: doc/BRIEF.md
# Virtualization Intercept Decision Unit

This unit decides, one event at a time, whether something a guest does must leave the guest and return control to the host. At guest entry it captures a set of intercept bitmaps in one cycle and sets its enable flag. The bitmaps cover control-register reads, control-register writes, debug-register reads, debug-register writes, exceptions, and a 64-bit general vector. Each event arrives as a strobe with a code and a 64-bit parameter. The code is sorted into one of several contiguous ranges. Each range tests its own bitmap at bit (code − range base). Codes in the general window test the 64-bit vector.

A hit produces a one-cycle exit request. The request carries the event's code and parameter. Model-specific-register accesses are not decided here. When their general bit is set, they are handed to a separate permission lookup as a forward pulse. A guest exit input clears the enable flag and zeroes the exception bitmap.

Top module: `intercept_decider`

## Requirements
- R1: While the enable flag is clear, no event raises `exit_req` or `msr_fwd`, whatever the bitmaps hold; guest exit clears the flag.
- R2: Control-register read codes 0x000–0x008 exit when bit (code − 0x000) of the read bitmap is set. Code 0x009 belongs to no range and never exits, even with bit 9 of that bitmap set.
- R3: Control-register write codes 0x010–0x018 exit when bit (code − 0x010) of the write bitmap is set.
- R4: Debug-register read codes 0x020–0x027 and write codes 0x030–0x037 each exit on bit (code − base) of their own 16-bit bitmap.
- R5: Exception codes 0x040–0x05F exit on bit (code − 0x040) of the 32-bit exception bitmap.
- R6: Codes 0x060–0x09F exit on bit (code − 0x060) of the 64-bit general vector. Codes at 0x0A0 and above never exit.
- R7: A `load` strobe captures all six bitmaps and sets the enable flag. When `load` and `vm_exit` fall in the same cycle, the exit wins and the unit ends disabled.
- R8: A hit raises `exit_req` for exactly the cycle after the strobe, with `exit_code` equal to the event code and `exit_info` equal to its parameter. Back-to-back hits give back-to-back pulses.
- R9: Code 0x07C (general bit 28) never raises `exit_req`. When enabled with that bit set, it raises `msr_fwd` for one cycle, with the code and parameter on `exit_code`/`exit_info`.
- R10: An event in the same cycle as `load` or `vm_exit` is judged against the bitmaps and enable flag held before that edge.
- R11: A synchronous active-high reset clears every bitmap, the enable flag, `exit_req` and `msr_fwd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Guest entry: capture bitmaps, set enable |
| vm_exit | input | 1 | Guest exit: clear enable, zero exception bitmap |
| ld_cr_rd | input | 16 | Control-register read bitmap to capture |
| ld_cr_wr | input | 16 | Control-register write bitmap to capture |
| ld_dr_rd | input | 16 | Debug-register read bitmap to capture |
| ld_dr_wr | input | 16 | Debug-register write bitmap to capture |
| ld_exc | input | 32 | Exception bitmap to capture |
| ld_gen | input | 64 | General intercept vector to capture |
| evt_valid | input | 1 | Event strobe |
| evt_code | input | 12 | Event code |
| evt_param | input | 64 | Event parameter |
| exit_req | output | 1 | One-cycle exit request |
| msr_fwd | output | 1 | One-cycle forward to the register-permission lookup |
| exit_code | output | 12 | Code of the last decided event |
| exit_info | output | 64 | Parameter of the last decided event |

## Verification
Two things can land in the same cycle: an event decision, and a state change from `load` or `vm_exit`. The bench drives an event strobe in the very cycle that new bitmaps are captured. It expects the verdict from the old bitmaps: no exit while still disabled, and a hit from the old map just before a reload clears it. It also strobes an exception event together with `vm_exit` and expects an exit, then expects none one cycle later. A simultaneous `load` and `vm_exit` must leave the unit disabled.

// File: rtl/intercept_decider.sv
module intercept_decider #(
  parameter int CW = 12,
  parameter int IW = 64,
  parameter logic [CW-1:0] CR_RD_BASE = 12'h000,
  parameter logic [CW-1:0] CR_WR_BASE = 12'h010,
  parameter logic [CW-1:0] DR_RD_BASE = 12'h020,
  parameter logic [CW-1:0] DR_WR_BASE = 12'h030,
  parameter logic [CW-1:0] EXC_BASE   = 12'h040,
  parameter logic [CW-1:0] GEN_BASE   = 12'h060,
  parameter logic [CW-1:0] MSR_CODE   = 12'h07C,
  parameter int CR_CNT  = 9,
  parameter int DR_CNT  = 8,
  parameter int EXC_CNT = 32,
  parameter int GEN_CNT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          vm_exit,
  input  logic [15:0]   ld_cr_rd,
  input  logic [15:0]   ld_cr_wr,
  input  logic [15:0]   ld_dr_rd,
  input  logic [15:0]   ld_dr_wr,
  input  logic [31:0]   ld_exc,
  input  logic [63:0]   ld_gen,
  input  logic          evt_valid,
  input  logic [CW-1:0] evt_code,
  input  logic [IW-1:0] evt_param,
  output logic          exit_req,
  output logic          msr_fwd,
  output logic [CW-1:0] exit_code,
  output logic [IW-1:0] exit_info
);
  localparam logic [CW-1:0] CR_N  = CW'(CR_CNT);
  localparam logic [CW-1:0] DR_N  = CW'(DR_CNT);
  localparam logic [CW-1:0] EXC_N = CW'(EXC_CNT);
  localparam logic [CW-1:0] GEN_N = CW'(GEN_CNT);

  logic        en;
  logic [15:0] cr_rd, cr_wr, dr_rd, dr_wr;
  logic [31:0] exc;
  logic [63:0] gen;

  wire [CW-1:0] o_crr = evt_code - CR_RD_BASE;
  wire [CW-1:0] o_crw = evt_code - CR_WR_BASE;
  wire [CW-1:0] o_drr = evt_code - DR_RD_BASE;
  wire [CW-1:0] o_drw = evt_code - DR_WR_BASE;
  wire [CW-1:0] o_exc = evt_code - EXC_BASE;
  wire [CW-1:0] o_gen = evt_code - GEN_BASE;

  wire in_crr = o_crr < CR_N;
  wire in_crw = o_crw < CR_N;
  wire in_drr = o_drr < DR_N;
  wire in_drw = o_drw < DR_N;
  wire in_exc = o_exc < EXC_N;
  wire in_gen = (o_gen < GEN_N) && !(in_crr || in_crw || in_drr || in_drw || in_exc);

  logic hit;
  always_comb begin
    if (in_crr)      hit = cr_rd[o_crr[3:0]];
    else if (in_crw) hit = cr_wr[o_crw[3:0]];
    else if (in_drr) hit = dr_rd[o_drr[3:0]];
    else if (in_drw) hit = dr_wr[o_drw[3:0]];
    else if (in_exc) hit = exc[o_exc[4:0]];
    else if (in_gen) hit = gen[o_gen[5:0]];
    else             hit = 1'b0;
  end

  wire is_msr = evt_code == MSR_CODE;
  wire take   = evt_valid && en && hit;
  wire exit_d = take && !is_msr;
  wire fwd_d  = take && is_msr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
      cr_rd <= '0; cr_wr <= '0; dr_rd <= '0; dr_wr <= '0;
      exc <= '0; gen <= '0;
      exit_req <= 1'b0; msr_fwd <= 1'b0;
      exit_code <= '0; exit_info <= '0;
    end else begin
      exit_req <= exit_d;
      msr_fwd  <= fwd_d;
      if (take) begin
        exit_code <= evt_code;
        exit_info <= evt_param;
      end
      if (vm_exit) begin
        en  <= 1'b0;
        exc <= '0;
      end else if (load) begin
        en <= 1'b1;
        cr_rd <= ld_cr_rd; cr_wr <= ld_cr_wr;
        dr_rd <= ld_dr_rd; dr_wr <= ld_dr_wr;
        exc <= ld_exc; gen <= ld_gen;
      end
    end
  end
endmodule

// File: rtl/intercept_decider_chk.sv
module intercept_decider_chk #(
  parameter int CW = 12,
  parameter int IW = 64,
  parameter logic [CW-1:0] MSR_CODE = 12'h07C
) (
  input logic          clk,
  input logic          rst,
  input logic          vm_exit,
  input logic          evt_valid,
  input logic [CW-1:0] evt_code,
  input logic [IW-1:0] evt_param,
  input logic          exit_req,
  input logic          msr_fwd,
  input logic [CW-1:0] exit_code,
  input logic [IW-1:0] exit_info
);
  AST_EXIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    exit_req |-> $past(evt_valid)); // R8
  AST_EXIT_ECHO: assert property (@(posedge clk) disable iff (rst)
    exit_req |-> (exit_code == $past(evt_code) && exit_info == $past(evt_param))); // R8
  AST_NO_EXIT_AFTER_LEAVE: assert property (@(posedge clk) disable iff (rst)
    (vm_exit ##1 evt_valid) |=> !exit_req && !msr_fwd); // R1
  AST_MSR_NOT_EXIT: assert property (@(posedge clk) disable iff (rst)
    msr_fwd |-> !exit_req && $past(evt_code) == MSR_CODE); // R9
  AST_MSR_NEVER_EXITS: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == MSR_CODE) |=> !exit_req); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !exit_req && !msr_fwd); // R11
endmodule

bind intercept_decider intercept_decider_chk #(.CW(CW), .IW(IW), .MSR_CODE(MSR_CODE)) u_chk (
  .clk(clk), .rst(rst), .vm_exit(vm_exit), .evt_valid(evt_valid),
  .evt_code(evt_code), .evt_param(evt_param), .exit_req(exit_req),
  .msr_fwd(msr_fwd), .exit_code(exit_code), .exit_info(exit_info)
);

// File: tb/intercept_decider_tb.sv
module intercept_decider_tb;
  logic clk = 0, rst = 1, load = 0, vm_exit = 0, evt_valid = 0;
  logic [15:0] ld_cr_rd = 0, ld_cr_wr = 0, ld_dr_rd = 0, ld_dr_wr = 0;
  logic [31:0] ld_exc = 0;
  logic [63:0] ld_gen = 0;
  logic [11:0] evt_code = 0;
  logic [63:0] evt_param = 0;
  logic exit_req, msr_fwd;
  logic [11:0] exit_code;
  logic [63:0] exit_info;

  always #2 clk = ~clk;

  intercept_decider u_dut (
    .clk(clk), .rst(rst), .load(load), .vm_exit(vm_exit),
    .ld_cr_rd(ld_cr_rd), .ld_cr_wr(ld_cr_wr), .ld_dr_rd(ld_dr_rd), .ld_dr_wr(ld_dr_wr),
    .ld_exc(ld_exc), .ld_gen(ld_gen), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_param(evt_param), .exit_req(exit_req), .msr_fwd(msr_fwd),
    .exit_code(exit_code), .exit_info(exit_info)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  bit          q_ex[$], q_fw[$];
  logic [11:0] q_code[$];
  logic [63:0] q_info[$];
  string       q_tag[$];

  bit m_en = 0;
  logic [15:0] m_crr = 0, m_crw = 0, m_drr = 0, m_drw = 0;
  logic [31:0] m_exc = 0;
  logic [63:0] m_gen = 0;

  function automatic bit model_hit(logic [11:0] c);
    if (c <= 12'h008) return m_crr[c - 12'h000];
    if (c >= 12'h010 && c <= 12'h018) return m_crw[c - 12'h010];
    if (c >= 12'h020 && c <= 12'h027) return m_drr[c - 12'h020];
    if (c >= 12'h030 && c <= 12'h037) return m_drw[c - 12'h030];
    if (c >= 12'h040 && c <= 12'h05F) return m_exc[c - 12'h040];
    if (c >= 12'h060 && c <= 12'h09F) return m_gen[c - 12'h060];
    return 0;
  endfunction

  task automatic step(bit ld, bit ve, bit ev, logic [11:0] c, logic [63:0] p, string tag);
    bit h;
    @(negedge clk);
    load = ld; vm_exit = ve; evt_valid = ev; evt_code = c; evt_param = p;
    h = ev && m_en && model_hit(c);
    q_ex.push_back(h && c != 12'h07C);
    q_fw.push_back(h && c == 12'h07C);
    q_code.push_back(c);
    q_info.push_back(p);
    q_tag.push_back(tag);
    if (ve) begin m_en = 0; m_exc = 0; end
    else if (ld) begin
      m_en = 1; m_crr = ld_cr_rd; m_crw = ld_cr_wr; m_drr = ld_dr_rd;
      m_drw = ld_dr_wr; m_exc = ld_exc; m_gen = ld_gen;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && q_ex.size() > 0) begin
      bit e, f; logic [11:0] c; logic [63:0] p; string t; bit bad;
      e = q_ex.pop_front(); f = q_fw.pop_front(); c = q_code.pop_front();
      p = q_info.pop_front(); t = q_tag.pop_front();
      bad = (exit_req !== e) || (msr_fwd !== f);
      if (e || f) bad = bad || (exit_code !== c) || (exit_info !== p);
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s: exit=%b fwd=%b code=%h info=%h expected exit=%b fwd=%b code=%h info=%h",
                 t, exit_req, msr_fwd, exit_code, exit_info, e, f, c, p);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exit_req !== 0 || msr_fwd !== 0) begin
      fails++;
      $display("FAIL R11: exit=%b fwd=%b expected 0 0", exit_req, msr_fwd);
    end
    rst = 0;
    step(0, 0, 1, 12'h000, 64'h1, "R11 disabled after reset");
    step(0, 0, 1, 12'h060, 64'h2, "R1 disabled");
    ld_cr_rd = 16'h0305; ld_cr_wr = 16'h0002; ld_dr_rd = 16'h0080; ld_dr_wr = 16'h0001;
    ld_exc = 32'h8000_4001; ld_gen = 64'h0000_0001_1000_0003;
    step(1, 0, 1, 12'h000, 64'h3, "R10 event with load uses old state");
    step(0, 0, 1, 12'h000, 64'hA0, "R2 cr read bit0");
    step(0, 0, 1, 12'h001, 64'hA1, "R2 cr read bit1 clear");
    step(0, 0, 1, 12'h008, 64'hA8, "R2 cr read last code");
    step(0, 0, 1, 12'h009, 64'hA9, "R2 gap code");
    step(0, 0, 1, 12'h011, 64'hB1, "R3 cr write bit1");
    step(0, 0, 1, 12'h010, 64'hB0, "R3 cr write bit0 clear");
    step(0, 0, 1, 12'h027, 64'hC7, "R4 dr read bit7");
    step(0, 0, 1, 12'h030, 64'hD0, "R4 dr write bit0");
    step(0, 0, 1, 12'h031, 64'hD1, "R4 dr write bit1 clear");
    step(0, 0, 1, 12'h040, 64'hE0, "R5 exc bit0");
    step(0, 0, 1, 12'h04E, 64'hE14, "R5 exc bit14");
    step(0, 0, 1, 12'h05F, 64'hE31, "R5 exc bit31");
    step(0, 0, 1, 12'h041, 64'hE1, "R5 exc bit1 clear");
    step(0, 0, 1, 12'h060, 64'h1234_5678_9ABC_DEF0, "R8 gen bit0");
    step(0, 0, 1, 12'h061, 64'hFEDC_BA98_7654_3210, "R8 back to back gen bit1");
    step(0, 0, 1, 12'h062, 64'hF2, "R6 gen bit2 clear");
    step(0, 0, 1, 12'h080, 64'hF32, "R6 gen bit32");
    step(0, 0, 1, 12'h0A0, 64'hFF, "R6 beyond window");
    step(0, 0, 1, 12'h07C, 64'hC000_0080, "R9 msr forward");
    step(0, 0, 0, 12'h000, 64'h0, "R8 idle no pulse");
    ld_cr_rd = 16'h0000;
    step(1, 0, 1, 12'h000, 64'h11, "R10 reload judged by old map");
    step(0, 0, 1, 12'h000, 64'h12, "R7 new map captured");
    step(0, 1, 1, 12'h040, 64'h13, "R10 event with vm_exit still enabled");
    step(0, 0, 1, 12'h040, 64'h14, "R1 after vm_exit");
    step(1, 1, 0, 12'h000, 64'h0, "R7 load with exit");
    step(0, 0, 1, 12'h060, 64'h15, "R7 exit wins over load");
    step(1, 0, 0, 12'h000, 64'h0, "R7 reload");
    step(0, 0, 1, 12'h060, 64'h16, "R7 enabled after load");
    ld_gen = 64'h0000_0000_0000_0001;
    step(1, 0, 0, 12'h000, 64'h0, "R9 reload without msr bit");
    step(0, 0, 1, 12'h07C, 64'h17, "R9 msr bit clear");
    step(0, 0, 0, 12'h000, 64'h0, "idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule